// File: doc/BRIEF.md
# Two-Node Pipelined Bus Arbiter

This block decides which of two masters drives a shared 64-bit multiplexed address/data bus on the next bus cycle. One master is the processor. The other is the system interface bridge, which asks for the bus only to return read data or to pass on snooped invalidate addresses. The arbiter does not touch the bus wires. It only produces the two grants, a lock indication and an owner code.

The choice for the next cycle is made while the current cycle's beat is on the bus. Each grant is a flop loaded at the end of the cycle in which the request was seen. A beat on the bus is any cycle in which a master holds its grant and has its request high. A master ends its transfer by raising its last-beat input on the final beat. Ownership passes only at such boundaries. When nobody requests, the bus is parked on the processor, so the processor can start a transfer with no wait.

The bridge has fixed priority because another agent is always waiting on it. After reset, both grants stay low for a programmable number of cycles (one by default), and then the bus parks.

Top module: `bus_arb2`

## Requirements
- R1: While the reset input is low, and for RESET_IDLE cycles (default 1) after it goes high, both grants, the lock flag and the owner code are all zero.
- R2: When no transfer is locked and the bridge is not requesting, the processor holds the grant in the next cycle (parking). This also applies when the bridge is granted but drops its request.
- R3: A bridge request seen in a cycle where the bus is free and the bridge is not granted yields the bridge grant in the very next cycle.
- R4: If the processor is not mid-transfer and the bridge requests, the bridge is granted next cycle, even when the processor requests or makes a single-beat access in the same cycle.
- R5: A beat with request high and last-beat low by the grant holder keeps that holder's grant for the next cycle, whatever the other master requests.
- R6: On the owner's last beat, the next owner's grant appears in the following cycle with no idle cycle. A bridge last beat always hands the bus to the processor, because the owner's own request on its final beat is not counted as a new request.
- R7: At most one grant is high in any cycle.
- R8: bus_busy is high in a cycle exactly when the previous cycle carried a non-last beat by the grant holder.
- R9: bus_owner is 2'b01 when the processor is granted, 2'b10 when the bridge is granted, and 2'b00 when neither is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor wants or is using the bus |
| cpu_last | input | 1 | Processor beat is the final beat of its transfer |
| brg_req | input | 1 | Bridge wants or is using the bus |
| brg_last | input | 1 | Bridge beat is the final beat of its transfer |
| cpu_gnt | output | 1 | Processor owns the bus this cycle |
| brg_gnt | output | 1 | Bridge owns the bus this cycle |
| bus_busy | output | 1 | Bus locked by a transfer still in progress |
| bus_owner | output | 2 | Owner code: 00 none, 01 processor, 10 bridge |

## Verification
The properties assume that a master keeps its request high on every beat of its transfer, and that the last-beat input matters only in a cycle where that master holds its grant and requests. The directed stimulus holds each request steady across a burst and raises last-beat only on the final granted beat. When a master is not granted, its last-beat input is either low or set to the value it will need on its first beat. Reset is also applied in the middle of a burst. This shows that the properties, which are disabled during reset, restart cleanly with the bus parked.

// File: rtl/bus_arb2_pkg.sv
package bus_arb2_pkg;

  // Owner code: one bit per master, bit 0 processor, bit 1 bridge.
  localparam int unsigned OWN_W = 2;

  typedef enum logic [OWN_W-1:0] {
    OWN_NONE = 2'b00,
    OWN_CPU  = 2'b01,
    OWN_BRG  = 2'b10
  } owner_e;

endpackage

// File: rtl/bus_arb2_beat.sv
// Classifies what one master is doing on the bus in the current cycle.
module bus_arb2_beat (
  input  logic gnt,
  input  logic req,
  input  logic last,
  output logic beat,
  output logic hold
);

  always_comb begin
    beat = gnt & req;
    hold = beat & ~last;
  end

endmodule

// File: rtl/bus_arb2_pick.sv
// Next-cycle owner decision, evaluated alongside the current beat.
module bus_arb2_pick
  import bus_arb2_pkg::*;
(
  input  logic   idle_done,
  input  logic   cpu_hold,
  input  logic   brg_hold,
  input  logic   brg_req,
  input  logic   brg_gnt,
  output owner_e own_nxt,
  output logic   busy_nxt
);

  always_comb begin
    busy_nxt = cpu_hold | brg_hold;
    if (!idle_done) begin
      own_nxt = OWN_NONE;
    end else if (cpu_hold) begin
      own_nxt = OWN_CPU;
    end else if (brg_hold) begin
      own_nxt = OWN_BRG;
    end else if (brg_req && !brg_gnt) begin
      own_nxt = OWN_BRG;
    end else begin
      own_nxt = OWN_CPU;
    end
    if (!idle_done) begin
      busy_nxt = 1'b0;
    end
  end

endmodule

// File: rtl/bus_arb2_regs.sv
// State flops: owner code, grant flops, lock flag and post-reset idle counter.
module bus_arb2_regs
  import bus_arb2_pkg::*;
#(
  parameter int unsigned RESET_IDLE = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  owner_e own_nxt,
  input  logic   busy_nxt,
  output logic   idle_done,
  output logic   cpu_gnt,
  output logic   brg_gnt,
  output logic   bus_busy,
  output owner_e own_q
);

  localparam int unsigned CNT_W    = (RESET_IDLE < 2) ? 1 : $clog2(RESET_IDLE);
  localparam int unsigned CNT_LAST = (RESET_IDLE < 1) ? 0 : RESET_IDLE - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    idle_done = (cnt_q == CNT_W'(CNT_LAST));
    cnt_en    = ~idle_done;
    cnt_d     = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= OWN_NONE;
      cpu_gnt  <= 1'b0;
      brg_gnt  <= 1'b0;
      bus_busy <= 1'b0;
    end else begin
      own_q    <= own_nxt;
      cpu_gnt  <= (own_nxt == OWN_CPU);
      brg_gnt  <= (own_nxt == OWN_BRG);
      bus_busy <= busy_nxt;
    end
  end

endmodule

// File: rtl/bus_arb2.sv
module bus_arb2
  import bus_arb2_pkg::*;
#(
  parameter int unsigned RESET_IDLE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_last,
  input  logic             brg_req,
  input  logic             brg_last,
  output logic             cpu_gnt,
  output logic             brg_gnt,
  output logic             bus_busy,
  output logic [OWN_W-1:0] bus_owner
);

  localparam int unsigned NODES = 2;

  logic [NODES-1:0] gnt_v;
  logic [NODES-1:0] req_v;
  logic [NODES-1:0] last_v;
  logic [NODES-1:0] beat_v;
  logic [NODES-1:0] hold_v;
  logic             idle_done;
  logic             busy_nxt;
  owner_e           own_nxt;
  owner_e           own_q;

  always_comb begin
    gnt_v  = {brg_gnt, cpu_gnt};
    req_v  = {brg_req, cpu_req};
    last_v = {brg_last, cpu_last};
  end

  for (genvar n = 0; n < NODES; n++) begin : g_node
    bus_arb2_beat u_beat (
      .gnt  (gnt_v[n]),
      .req  (req_v[n]),
      .last (last_v[n]),
      .beat (beat_v[n]),
      .hold (hold_v[n])
    );
  end

  bus_arb2_pick u_pick (
    .idle_done (idle_done),
    .cpu_hold  (hold_v[0]),
    .brg_hold  (hold_v[1]),
    .brg_req   (brg_req),
    .brg_gnt   (brg_gnt),
    .own_nxt   (own_nxt),
    .busy_nxt  (busy_nxt)
  );

  bus_arb2_regs #(.RESET_IDLE(RESET_IDLE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_nxt   (own_nxt),
    .busy_nxt  (busy_nxt),
    .idle_done (idle_done),
    .cpu_gnt   (cpu_gnt),
    .brg_gnt   (brg_gnt),
    .bus_busy  (bus_busy),
    .own_q     (own_q)
  );

  assign bus_owner = own_q;

endmodule

// File: rtl/bus_arb2_chk.sv
module bus_arb2_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_last,
  input logic       brg_req,
  input logic       brg_last,
  input logic       cpu_gnt,
  input logic       brg_gnt,
  input logic       bus_busy,
  input logic [1:0] bus_owner
);

  logic cpu_mid;
  logic brg_mid;
  assign cpu_mid = cpu_gnt && cpu_req && !cpu_last;
  assign brg_mid = brg_gnt && brg_req && !brg_last;

  a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brg_gnt, cpu_gnt}));

  a_r9_owner_code: assert property (@(posedge clk) disable iff (!rst_n)
    bus_owner == {brg_gnt, cpu_gnt});

  a_r5_cpu_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mid |=> cpu_gnt);

  a_r5_brg_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    brg_mid |=> brg_gnt);

  a_r4_brg_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !cpu_mid && brg_req) |=> brg_gnt);

  a_r6_handback: assert property (@(posedge clk) disable iff (!rst_n)
    (brg_gnt && brg_req && brg_last) |=> cpu_gnt);

  a_r2_park: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_gnt || brg_gnt) && !brg_req) |=> cpu_gnt);

  a_r8_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mid || brg_mid) |=> bus_busy);

  a_r8_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_mid || brg_mid) |=> !bus_busy);

endmodule

bind bus_arb2 bus_arb2_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_last  (cpu_last),
  .brg_req   (brg_req),
  .brg_last  (brg_last),
  .cpu_gnt   (cpu_gnt),
  .brg_gnt   (brg_gnt),
  .bus_busy  (bus_busy),
  .bus_owner (bus_owner)
);

// File: tb/bus_arb2_tb_top.sv
`timescale 1ns/1ps
module bus_arb2_tb_top;

  logic       clk;
  logic       rst_n;
  logic       cpu_req, cpu_last, brg_req, brg_last;
  logic       cpu_gnt, brg_gnt, bus_busy;
  logic [1:0] bus_owner;

  int total = 0;
  int bad   = 0;

  bus_arb2 dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_last  (cpu_last),
    .brg_req   (brg_req),
    .brg_last  (brg_last),
    .cpu_gnt   (cpu_gnt),
    .brg_gnt   (brg_gnt),
    .bus_busy  (bus_busy),
    .bus_owner (bus_owner)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic drive(input logic cr, input logic cl, input logic br, input logic bl);
    cpu_req  = cr;
    cpu_last = cl;
    brg_req  = br;
    brg_last = bl;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(input string tag, input logic cg, input logic bg, input logic bz);
    logic [4:0] act;
    logic [4:0] exp;
    act = {cpu_gnt, brg_gnt, bus_busy, bus_owner};
    exp = {cg, bg, bz, bg, cg};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {cpu_gnt,brg_gnt,busy,owner} actual=%b expected=%b at %0t",
               tag, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    drive(0, 0, 0, 0);
    rst_n = 1'b0;
    tick();
    expect_out("R1 in reset", 0, 0, 0);
    tick();
    expect_out("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    #1;
    expect_out("R1 idle cycle after release", 0, 0, 0);
    tick();
    expect_out("R2 park after idle", 1, 0, 0);
  endtask

  task automatic t_cpu_single();
    drive(1, 1, 0, 0);
    tick();
    expect_out("R2 single cpu beat stays parked", 1, 0, 0);
    drive(0, 0, 0, 0);
    tick();
    expect_out("R2 no requests", 1, 0, 0);
  endtask

  task automatic t_bursts();
    drive(1, 0, 1, 0);
    tick();
    expect_out("R5 cpu burst holds vs bridge", 1, 0, 1);
    tick();
    expect_out("R5 cpu burst holds again", 1, 0, 1);
    drive(1, 1, 1, 0);
    tick();
    expect_out("R4 R6 bridge after cpu last", 0, 1, 0);
    drive(0, 0, 1, 0);
    tick();
    expect_out("R8 bridge burst busy", 0, 1, 1);
    drive(1, 0, 1, 0);
    tick();
    expect_out("R5 bridge holds vs cpu", 0, 1, 1);
    drive(1, 0, 1, 1);
    tick();
    expect_out("R6 cpu right after bridge last", 1, 0, 0);
    drive(1, 0, 0, 0);
    tick();
    expect_out("R8 cpu burst busy", 1, 0, 1);
    drive(1, 1, 0, 0);
    tick();
    expect_out("R8 busy clears after last", 1, 0, 0);
    drive(0, 0, 0, 0);
  endtask

  task automatic t_brg_from_park();
    drive(0, 0, 1, 1);
    tick();
    expect_out("R3 bridge grant next cycle", 0, 1, 0);
    tick();
    expect_out("R6 single bridge beat hands back", 1, 0, 0);
    drive(0, 0, 0, 0);
    tick();
    expect_out("R2 parked", 1, 0, 0);
  endtask

  task automatic t_brg_drop();
    drive(0, 0, 1, 0);
    tick();
    expect_out("R3 bridge grant", 0, 1, 0);
    drive(0, 0, 0, 0);
    tick();
    expect_out("R2 bridge drops request", 1, 0, 0);
  endtask

  task automatic t_priority();
    drive(1, 1, 1, 0);
    tick();
    expect_out("R4 bridge beats cpu single beat", 0, 1, 0);
    drive(1, 0, 1, 1);
    tick();
    expect_out("R6 hand back with cpu waiting", 1, 0, 0);
    drive(0, 0, 0, 0);
    tick();
    expect_out("R7 R9 single owner", 1, 0, 0);
  endtask

  task automatic t_mid_reset();
    drive(1, 0, 1, 0);
    tick();
    expect_out("R5 cpu burst before reset", 1, 0, 1);
    rst_n = 1'b0;
    #1;
    expect_out("R1 async reset mid burst", 0, 0, 0);
    drive(0, 0, 0, 0);
    tick();
    rst_n = 1'b1;
    #1;
    expect_out("R1 idle after second release", 0, 0, 0);
    tick();
    expect_out("R2 park after second reset", 1, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0);
    #2;
    t_reset();
    t_cpu_single();
    t_bursts();
    t_brg_from_park();
    t_brg_drop();
    t_priority();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule